// File: doc/BRIEF.md
# Geometry Coprocessor Register File

This block holds the complete architectural register state of a 3D geometry coprocessor: 64 words of 32 bits in one flat index space. The lower half (indices 0 to 31) forms the data bank and the upper half (32 to 63) the control bank. A transfer names a bank with a one-bit bank select and a register with the 5-bit field from the instruction, so the flat index is the field plus 32 when the control bank is chosen.

Writes go through one synchronous port and reads come from one combinational port. Several indices change the stored value or reach into other entries on a write. Some store the low half-word extended by sign or by zero. A push alias shifts a three-deep screen-coordinate queue. A packed 5:5:5 colour word expands into three intensity registers. The status flag word is masked and carries a summary error bit. A leading-bit counter result follows its source register. Two indices read differently from what they store: the push alias reads the newest queue entry, and the packed colour word is rebuilt from the three intensity registers.

A raw access mode bypasses every one of these rules, so the whole file can be saved and restored word for word. Reset clears all 64 entries.

Top module: `gcop_regfile`

## Requirements
- R1: The flat index of either port is its 5-bit field plus 32 when its bank select is 1, and the field alone when the bank select is 0.
- R2: A normal write to index 1, 3, 5, 8, 9, 10, 11, 36, 44, 52, 58, 59, 61 or 62 stores bits 15:0 of the data sign-extended to 32 bits.
- R3: A normal write to an index from 16 to 19 stores bits 15:0 zero-extended.
- R4: A normal write to index 15 moves entry 13 to entry 12, moves entry 14 to entry 13 and puts the data into entry 14, all in one edge. A normal read of index 15 returns entry 14.
- R5: A normal write to index 28 stores data bits 14:0 with zeros above them. In the same edge, indices 9, 10 and 11 receive data bits 4:0, 9:5 and 14:10 respectively, each shifted left by 7 with zeros elsewhere.
- R6: A normal read of index 28 returns red in bits 4:0, green in 9:5 and blue in 14:10, with zeros above bit 14. Each component is the signed value of entry 9, 10 or 11 shifted right arithmetically by 7 and clamped to the range 0 to 31.
- R7: A normal write to index 63 stores the data ANDed with 0x7FFFF000. Bit 31 of the stored word is then the OR of stored bits 30:23 and 18:13.
- R8: A normal write to index 30 stores the data and sets index 31 to the count of leading bits equal to data bit 31, which is 32 when all bits are equal. A normal write to index 31 changes nothing.
- R9: A normal write to any index not named in R2 to R8 stores all 32 bits unchanged.
- R10: While reset is low, every entry reads zero.
- R11: With raw access set, a write stores the full data word only into the addressed entry, and a read returns the stored entry of the addressed index without mirroring or packing.
- R12: The read port is combinational and shows a write in the cycle after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low reset that clears the file |
| wrEn | input | 1 | Write strobe |
| wrCtrl | input | 1 | Write bank select, 1 = control bank |
| wrField | input | 5 | Write register field |
| wrData | input | 32 | Write data |
| rdCtrl | input | 1 | Read bank select, 1 = control bank |
| rdField | input | 5 | Read register field |
| rawAccess | input | 1 | Bypasses all write and read rules, used for save and restore |
| rdData | output | 32 | Read data |

## Verification
Every write, including the queue shift, the colour expansion, the flag fixup and the leading-bit count, takes effect at the single rising edge where the strobe is sampled. The result is visible on the combinational read port from then on. The bench drives each write on a falling edge and releases it on the next falling edge. It then sets the read address and samples one time unit later, so each result is checked exactly one edge after its stimulus. One check holds the write and the read together across an edge to show the old value before the edge and the new value after it.

// File: rtl/gcop_pkg.sv
package gcop_pkg;
  parameter int REG_W   = 32;
  parameter int FIELD_W = 5;
  localparam int IDX_W   = FIELD_W + 1;
  localparam int NUM_REG = 1 << IDX_W;
  localparam int HALF_W  = REG_W / 2;
  localparam int COL_W   = 5;
  localparam int COL_SH  = 7;
  localparam int CNT_W   = $clog2(REG_W + 1);

  localparam logic [IDX_W-1:0] IDX_Q0    = 6'd12;
  localparam logic [IDX_W-1:0] IDX_Q1    = 6'd13;
  localparam logic [IDX_W-1:0] IDX_Q2    = 6'd14;
  localparam logic [IDX_W-1:0] IDX_PUSH  = 6'd15;
  localparam logic [IDX_W-1:0] IDX_IRED  = 6'd9;
  localparam logic [IDX_W-1:0] IDX_IGRN  = 6'd10;
  localparam logic [IDX_W-1:0] IDX_IBLU  = 6'd11;
  localparam logic [IDX_W-1:0] IDX_COLOR = 6'd28;
  localparam logic [IDX_W-1:0] IDX_CSRC  = 6'd30;
  localparam logic [IDX_W-1:0] IDX_CRES  = 6'd31;
  localparam logic [IDX_W-1:0] IDX_FLAG  = 6'd63;
  localparam logic [REG_W-1:0] FLAG_MASK = 32'h7FFF_F000;

  typedef enum logic [1:0] {EXT_NONE, EXT_SIGN, EXT_ZERO} extKind_e;
  typedef enum logic [1:0] {RD_PLAIN, RD_MIRROR, RD_PACK} rdKind_e;

  typedef struct packed {
    logic             store;
    logic [IDX_W-1:0] idx;
    extKind_e         ext;
    logic             fifoPush;
    logic             colorExp;
    logic             flagWr;
    logic             cntUpd;
    rdKind_e          rdKind;
    logic [IDX_W-1:0] rdIdx;
  } strobe_t;

  function automatic logic [CNT_W-1:0] leadCount(input logic [REG_W-1:0] d);
    logic [CNT_W-1:0] cnt;
    logic done;
    cnt  = CNT_W'(1);
    done = 1'b0;
    for (int i = REG_W - 2; i >= 0; i--) begin
      if (!done && d[i] == d[REG_W-1]) cnt = cnt + CNT_W'(1);
      else done = 1'b1;
    end
    return cnt;
  endfunction

  function automatic logic [COL_W-1:0] clampComp(input logic [REG_W-1:0] r);
    logic signed [REG_W-1:0] q;
    q = $signed(r) >>> COL_SH;
    if (q < 0) return '0;
    else if (q > ((1 << COL_W) - 1)) return {COL_W{1'b1}};
    else return q[COL_W-1:0];
  endfunction

  function automatic logic [REG_W-1:0] expandComp(input logic [COL_W-1:0] c);
    return REG_W'(c) << COL_SH;
  endfunction
endpackage

// File: rtl/gcop_ctrl.sv
module gcop_ctrl
  import gcop_pkg::*;
(
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic             rawAccess,
  output strobe_t          st
);
  logic signSel;
  logic zeroSel;

  always_comb begin
    case (wrIdx)
      6'd1, 6'd3, 6'd5, 6'd8, 6'd9, 6'd10, 6'd11,
      6'd36, 6'd44, 6'd52, 6'd58, 6'd59, 6'd61, 6'd62: signSel = 1'b1;
      default: signSel = 1'b0;
    endcase
    zeroSel = (wrIdx >= 6'd16) && (wrIdx <= 6'd19);
  end

  always_comb begin
    st          = '0;
    st.idx      = wrIdx;
    st.rdIdx    = rdIdx;
    st.ext      = EXT_NONE;
    st.rdKind   = RD_PLAIN;
    if (rawAccess) begin
      st.store = wrEn;
    end else begin
      st.store    = wrEn && (wrIdx != IDX_CRES);
      st.fifoPush = (wrIdx == IDX_PUSH);
      st.colorExp = (wrIdx == IDX_COLOR);
      st.flagWr   = (wrIdx == IDX_FLAG);
      st.cntUpd   = (wrIdx == IDX_CSRC);
      if (signSel) st.ext = EXT_SIGN;
      else if (zeroSel) st.ext = EXT_ZERO;
      if (rdIdx == IDX_PUSH) st.rdKind = RD_MIRROR;
      else if (rdIdx == IDX_COLOR) st.rdKind = RD_PACK;
    end
  end
endmodule

// File: rtl/gcop_dpath.sv
module gcop_dpath
  import gcop_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        st,
  input  logic [REG_W-1:0]               wrData,
  output logic [REG_W-1:0]               rdData,
  output logic [NUM_REG-1:0][REG_W-1:0]  regArr
);
  logic [NUM_REG-1:0][REG_W-1:0] regQ;
  logic [REG_W-1:0] shaped;
  logic [REG_W-1:0] flagVal;
  logic [REG_W-1:0] packVal;

  always_comb begin
    case (st.ext)
      EXT_SIGN: shaped = {{HALF_W{wrData[HALF_W-1]}}, wrData[HALF_W-1:0]};
      EXT_ZERO: shaped = {{HALF_W{1'b0}}, wrData[HALF_W-1:0]};
      default:  shaped = wrData;
    endcase
    flagVal     = wrData & FLAG_MASK;
    flagVal[31] = (|flagVal[30:23]) | (|flagVal[18:13]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ <= '0;
    end else if (st.store) begin
      if (st.fifoPush) begin
        regQ[IDX_Q0] <= regQ[IDX_Q1];
        regQ[IDX_Q1] <= regQ[IDX_Q2];
        regQ[IDX_Q2] <= wrData;
      end else if (st.colorExp) begin
        regQ[IDX_COLOR] <= {{(REG_W-3*COL_W){1'b0}}, wrData[3*COL_W-1:0]};
        regQ[IDX_IRED]  <= expandComp(wrData[COL_W-1:0]);
        regQ[IDX_IGRN]  <= expandComp(wrData[2*COL_W-1:COL_W]);
        regQ[IDX_IBLU]  <= expandComp(wrData[3*COL_W-1:2*COL_W]);
      end else if (st.flagWr) begin
        regQ[IDX_FLAG] <= flagVal;
      end else begin
        regQ[st.idx] <= shaped;
        if (st.cntUpd) regQ[IDX_CRES] <= REG_W'(leadCount(wrData));
      end
    end
  end

  always_comb begin
    packVal = {{(REG_W-3*COL_W){1'b0}}, clampComp(regQ[IDX_IBLU]),
               clampComp(regQ[IDX_IGRN]), clampComp(regQ[IDX_IRED])};
    case (st.rdKind)
      RD_MIRROR: rdData = regQ[IDX_Q2];
      RD_PACK:   rdData = packVal;
      default:   rdData = regQ[st.rdIdx];
    endcase
  end

  assign regArr = regQ;
endmodule

// File: rtl/gcop_regfile.sv
module gcop_regfile
  import gcop_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               wrCtrl,
  input  logic [FIELD_W-1:0] wrField,
  input  logic [REG_W-1:0]   wrData,
  input  logic               rdCtrl,
  input  logic [FIELD_W-1:0] rdField,
  input  logic               rawAccess,
  output logic [REG_W-1:0]   rdData
);
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;
  strobe_t          st;
  logic [NUM_REG-1:0][REG_W-1:0] regArr;

  assign wrIdx = {wrCtrl, wrField};
  assign rdIdx = {rdCtrl, rdField};

  gcop_ctrl i_ctrl (
    .wrEn(wrEn), .wrIdx(wrIdx), .rdIdx(rdIdx), .rawAccess(rawAccess), .st(st)
  );

  gcop_dpath i_dpath (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData),
    .rdData(rdData), .regArr(regArr)
  );
endmodule

// File: rtl/gcop_regfile_chk.sv
module gcop_regfile_chk
  import gcop_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          wrEn,
  input logic                          rawAccess,
  input logic [IDX_W-1:0]              wrIdx,
  input logic [IDX_W-1:0]              rdIdx,
  input logic [REG_W-1:0]              wrData,
  input logic [REG_W-1:0]              rdData,
  input logic [NUM_REG-1:0][REG_W-1:0] regArr
);
  logic normWr;
  assign normWr = wrEn && !rawAccess;

  AST_QUEUE_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (normWr && wrIdx == IDX_PUSH) |=> (regArr[12] == $past(regArr[13])) && (regArr[13] == $past(regArr[14])) && (regArr[14] == $past(wrData))); // R4

  AST_ZERO_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (normWr && wrIdx == 6'd17) |=> (regArr[17][31:16] == 16'h0)); // R3

  AST_SIGN_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (normWr && wrIdx == 6'd36) |=> (regArr[36][31:16] == {16{regArr[36][15]}})); // R2

  AST_FLAG_SUMMARY: assert property (@(posedge clk) disable iff (!rstN)
    (normWr && wrIdx == IDX_FLAG) |=> (regArr[63][11:0] == 12'h0) && (regArr[63][31] == ((|regArr[63][30:23]) || (|regArr[63][18:13])))); // R7

  AST_COUNT_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (normWr && wrIdx == IDX_CRES) |=> $stable(regArr[31])); // R8

  AST_PACK_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (!rawAccess && rdIdx == IDX_COLOR) |-> (rdData[31:15] == 17'h0)); // R6
endmodule

bind gcop_regfile gcop_regfile_chk i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rawAccess(rawAccess),
  .wrIdx(wrIdx), .rdIdx(rdIdx), .wrData(wrData), .rdData(rdData), .regArr(regArr)
);

// File: tb/test_gcop_regfile.sv
module test_gcop_regfile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrCtrl = 1'b0;
  logic [4:0]  wrField = '0;
  logic [31:0] wrData = '0;
  logic        rdCtrl = 1'b0;
  logic [4:0]  rdField = '0;
  logic        rawAccess = 1'b0;
  logic [31:0] rdData;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gcop_regfile i_gcop_regfile (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCtrl(wrCtrl), .wrField(wrField),
    .wrData(wrData), .rdCtrl(rdCtrl), .rdField(rdField), .rawAccess(rawAccess),
    .rdData(rdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d, input bit raw = 1'b0);
    @(negedge clk);
    wrEn = 1'b1; wrCtrl = idx[5]; wrField = idx[4:0]; wrData = d; rawAccess = raw;
    @(negedge clk);
    wrEn = 1'b0; rawAccess = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] q, input bit raw = 1'b0);
    rdCtrl = idx[5]; rdField = idx[4:0]; rawAccess = raw;
    #1;
    q = rdData;
    rawAccess = 1'b0;
  endtask

  task automatic expectReg(input string req, input int idx, input logic [31:0] exp, input bit raw = 1'b0);
    logic [31:0] q;
    rd(idx, q, raw);
    check(req, q, exp);
  endtask

  function automatic logic [4:0] clampRef(input logic [31:0] r);
    int v;
    v = $signed(r) / 128;
    if ($signed(r) < 0 && ($signed(r) % 128) != 0) v = v - 1;
    if (v < 0) return 5'd0;
    if (v > 31) return 5'd31;
    return v[4:0];
  endfunction

  task automatic t_reset();
    expectReg("R10 idx0", 0, 32'h0);
    expectReg("R10 idx31", 31, 32'h0);
    expectReg("R10 idx63", 63, 32'h0);
  endtask

  task automatic t_addressing();
    wr(32 + 5, 32'hCAFE_0001);
    expectReg("R1 ctrl bank", 37, 32'hCAFE_0001);
    expectReg("R1 data bank untouched", 5, 32'h0);
  endtask

  task automatic t_extend();
    wr(1, 32'h1234_8001);
    expectReg("R2 idx1", 1, 32'hFFFF_8001);
    wr(36, 32'hAAAA_7FFF);
    expectReg("R2 idx36", 36, 32'h0000_7FFF);
    wr(62, 32'h0000_F00D);
    expectReg("R2 idx62", 62, 32'hFFFF_F00D);
    wr(17, 32'hFFFF_8001);
    expectReg("R3 idx17", 17, 32'h0000_8001);
  endtask

  task automatic t_queue();
    wr(15, 32'h0000_00A1);
    wr(15, 32'h0000_00B2);
    wr(15, 32'h0000_00C3);
    expectReg("R4 q0", 12, 32'hA1);
    expectReg("R4 q1", 13, 32'hB2);
    expectReg("R4 q2", 14, 32'hC3);
    expectReg("R4 alias read", 15, 32'hC3);
    wr(15, 32'h0000_00D4);
    expectReg("R4 q0 shifted", 12, 32'hB2);
    expectReg("R4 q2 new", 14, 32'hD4);
  endtask

  task automatic t_colorWrite();
    logic [31:0] d;
    d = 32'hFFFF_ABCD;
    wr(28, d);
    expectReg("R5 stored", 28, {17'h0, d[14:0]}, 1'b1);
    expectReg("R5 red", 9, {20'h0, d[4:0], 7'h0});
    expectReg("R5 green", 10, {20'h0, d[9:5], 7'h0});
    expectReg("R5 blue", 11, {20'h0, d[14:10], 7'h0});
    expectReg("R6 roundtrip", 28, {17'h0, d[14:0]});
  endtask

  task automatic t_colorRead();
    logic [31:0] r, g, b;
    r = 32'hFFFF_FF00; g = 32'h0000_7000; b = 32'h0000_0300;
    wr(9, r); wr(10, g); wr(11, b);
    expectReg("R6 clamp", 28, {17'h0, clampRef(b), clampRef(g), clampRef(r)});
    check("R6 ref sanity", {17'h0, clampRef(b), clampRef(g), clampRef(r)}, 32'h0000_1BE0);
  endtask

  task automatic t_flag();
    wr(63, 32'hFFFF_FFFF);
    expectReg("R7 all ones", 63, 32'hFFFF_F000);
    wr(63, 32'h0007_1000);
    expectReg("R7 low range", 63, 32'h8007_1000);
    wr(63, 32'h0000_1000);
    expectReg("R7 no summary", 63, 32'h0000_1000);
    wr(63, 32'h0040_0000);
    expectReg("R7 bit22 only", 63, 32'h0040_0000);
  endtask

  task automatic t_count();
    wr(30, 32'h00F0_0000);
    expectReg("R8 src stored", 30, 32'h00F0_0000);
    expectReg("R8 count 8", 31, 32'd8);
    wr(30, 32'hFFFF_FFFF);
    expectReg("R8 ones", 31, 32'd32);
    wr(30, 32'h0);
    expectReg("R8 zeros", 31, 32'd32);
    wr(30, 32'h8000_0000);
    expectReg("R8 one", 31, 32'd1);
    wr(31, 32'h0000_0055);
    expectReg("R8 direct ignored", 31, 32'd1);
  endtask

  task automatic t_plain();
    wr(0, 32'hDEAD_BEEF);
    expectReg("R9 idx0", 0, 32'hDEAD_BEEF);
    wr(56, 32'h1234_5678);
    expectReg("R9 idx56", 56, 32'h1234_5678);
  endtask

  task automatic t_raw();
    wr(1, 32'hFFFF_1234, 1'b1);
    expectReg("R11 raw no ext", 1, 32'hFFFF_1234);
    wr(15, 32'h0000_0077, 1'b1);
    expectReg("R11 q2 kept", 14, 32'hD4);
    expectReg("R11 raw read 15", 15, 32'h77, 1'b1);
    expectReg("R11 alias read 15", 15, 32'hD4);
    wr(31, 32'h0000_0099, 1'b1);
    expectReg("R11 raw write 31", 31, 32'h99);
  endtask

  task automatic t_timing();
    logic [31:0] q;
    @(negedge clk);
    wrEn = 1'b1; wrCtrl = 1'b0; wrField = 5'd2; wrData = 32'h5A5A_0002;
    rdCtrl = 1'b0; rdField = 5'd2;
    #1;
    q = rdData;
    check("R12 before edge", q, 32'h0);
    @(negedge clk);
    wrEn = 1'b0;
    #1;
    q = rdData;
    check("R12 after edge", q, 32'h5A5A_0002);
  endtask

  task automatic t_resetAgain();
    @(negedge clk);
    rstN = 1'b0;
    #2;
    expectReg("R10 clear idx0", 0, 32'h0);
    expectReg("R10 clear idx63", 63, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_addressing();
    t_extend();
    t_queue();
    t_colorWrite();
    t_colorRead();
    t_flag();
    t_count();
    t_plain();
    t_raw();
    t_timing();
    t_resetAgain();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule